// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A single counting channel whose behaviour comes from a 16-bit mode word. One counter serves five uses. It can count down and reload for periodic ticks. It can count up and snapshot its value on input edges to measure intervals. It can count edges seen on an external pin. It can run once from a trigger to give a delay or a one-shot pulse. It can count up between a start edge and the opposite edge to measure the width of a pulse. Every count step is gated by a count-clock enable, which lets a shared prescaler pace the channel. The external pin is synchronised and edge-detected inside the block.

Software programs the block through a one-bit-addressed register port: address 0 is the mode word and address 1 is the reload/compare data. A start strobe arms the channel. The results appear as the running counter, a capture register, a one-cycle interrupt pulse and a toggle output that flips on each terminal count.

Top module: `timer_chan`

## Requirements
- R1: After reset the mode word reads 0000h (interval mode) and data, counter, capture, interrupt and toggle are all 0.
- R2: Mode word bit 11 always reads 0 and a write to it is discarded; other mode bits and the data register read back as written (address 0 = mode, address 1 = data).
- R3: Mode bits [3:1]=000 (interval): a start loads the counter from data; then on each enabled count tick it decrements, and a tick at 0 reloads from data, pulses the interrupt and flips the toggle output.
- R4: Mode bits [3:1]=010 (capture): a start clears the counter; each enabled tick increments it; a valid input edge copies the counter to the capture register, clears the counter and pulses the interrupt.
- R5: Edge select is mode bits [7:6]: 00 falling, 01 rising, 10 and 11 both edges; in the pulse-width mode 10 starts on falling and stops on rising, 11 starts on rising and stops on falling (00 and 01 start on falling or rising and stop on the opposite edge).
- R6: Mode bits [3:1]=011 (event count): a start loads data; each valid edge decrements, and an edge at 0 reloads, pulses the interrupt and flips the toggle; the count enable is not used.
- R7: Mode bits [3:1]=100 (one-count): a trigger loads data, the counter counts down on enabled ticks, and a tick at 0 pulses the interrupt, flips the toggle and stops until the next trigger; trigger source bits [10:8]=000 means the start strobe, any other value means a valid input edge after a start.
- R8: In one-count mode, mode bit 0 = 1 lets a trigger during a count reload the counter; with bit 0 = 0 such a trigger is ignored.
- R9: Mode bits [3:1]=110 (pulse width): after a start, a start edge clears the counter and begins counting up; the opposite edge copies the counter to the capture register and pulses the interrupt; start edges during a measurement are ignored.
- R10: Any other mode bits [3:1] code keeps the counter, capture and toggle unchanged and raises no interrupt.
- R11: The pin passes through two synchroniser flops; an edge driven on the pin is acted on at the third rising clock edge after it.
- R12: Writing the mode word stops the channel: the counter holds until the next start.
- R13: Count ticks are taken only in cycles where the count enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countEn | input | 1 | Count tick enable |
| timerIn | input | 1 | External timer input pin, asynchronous |
| swStart | input | 1 | Start strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 mode, 1 data |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Read data of the selected register |
| cntValue | output | CNT_W | Current counter |
| capValue | output | CNT_W | Capture register |
| irqPulse | output | 1 | One-cycle interrupt |
| toggleOut | output | 1 | Output flipping on each terminal count |

## Verification
The hardest case to reach is the interaction of edges and triggers with a count in flight. Examples are a retrigger landing while a one-count run is mid-way, a start edge arriving during a width measurement, and an edge landing in the same cycle as a start strobe. The bench drives the pin and the count enable from a shift-register sequence that changes every few cycles, so these collisions happen many times in each mode. A behavioural model checks every cycle. A directed step also measures the three-cycle synchroniser latency on an isolated edge.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;
  localparam int MODE_W   = 16;
  localparam int RSVD_BIT = 11;
  localparam int EDGE_LO  = 6;
  localparam int TRIG_LO  = 8;

  typedef enum logic [2:0] {
    K_INTERVAL,
    K_CAPTURE,
    K_EVENT,
    K_ONESHOT,
    K_PULSEW,
    K_HALT
  } kind_e;

  typedef struct packed {
    logic load;
    logic clear;
    logic decr;
    logic incr;
    logic capture;
    logic irq;
    logic toggle;
  } strobe_t;

  function automatic kind_e decodeKind(input logic [2:0] code);
    case (code)
      3'b000:  return K_INTERVAL;
      3'b010:  return K_CAPTURE;
      3'b011:  return K_EVENT;
      3'b100:  return K_ONESHOT;
      3'b110:  return K_PULSEW;
      default: return K_HALT;
    endcase
  endfunction
endpackage

// File: rtl/timer_chan_ctrl.sv
module timer_chan_ctrl
  import timer_chan_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerIn,
  input  logic              swStart,
  input  logic              countEn,
  input  logic              modeWr,
  input  logic [MODE_W-1:0] modeWrData,
  input  logic              cntZero,
  output logic [MODE_W-1:0] modeQ,
  output strobe_t           strb
);
  localparam int TAP_NEW = SYNC_N - 1;
  localparam int TAP_OLD = SYNC_N;

  logic [SYNC_N:0] syncQ;
  logic enQ, enD, runQ, runD;
  logic rise, fall, anyEdge, startEdge, stopEdge, trig;
  kind_e kind;
  logic [1:0] edgeSel;
  logic [2:0] trigSel;
  logic retrig;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_N-1:0], timerIn};
  end

  assign rise = syncQ[TAP_NEW] & ~syncQ[TAP_OLD];
  assign fall = ~syncQ[TAP_NEW] & syncQ[TAP_OLD];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (modeWr) begin
      modeQ <= modeWrData;
      modeQ[RSVD_BIT] <= 1'b0;
    end
  end

  assign kind    = decodeKind(modeQ[3:1]);
  assign edgeSel = modeQ[EDGE_LO+1:EDGE_LO];
  assign trigSel = modeQ[TRIG_LO+2:TRIG_LO];
  assign retrig  = modeQ[0];

  always_comb begin
    case (edgeSel)
      2'b00:   anyEdge = fall;
      2'b01:   anyEdge = rise;
      default: anyEdge = rise | fall;
    endcase
    startEdge = edgeSel[0] ? rise : fall;
    stopEdge  = edgeSel[0] ? fall : rise;
  end

  always_comb begin
    strb = '0;
    enD  = enQ;
    runD = runQ;
    trig = (trigSel == 3'b000) ? swStart : (enQ & anyEdge);
    if (modeWr) begin
      enD  = 1'b0;
      runD = 1'b0;
    end else begin
      if (swStart && kind != K_HALT) enD = 1'b1;
      case (kind)
        K_INTERVAL: begin
          if (swStart) strb.load = 1'b1;
          else if (enQ && countEn) begin
            if (cntZero) begin
              strb.load = 1'b1; strb.irq = 1'b1; strb.toggle = 1'b1;
            end else strb.decr = 1'b1;
          end
        end
        K_CAPTURE: begin
          if (swStart) strb.clear = 1'b1;
          else if (enQ) begin
            if (anyEdge) begin
              strb.capture = 1'b1; strb.clear = 1'b1; strb.irq = 1'b1;
            end else if (countEn) strb.incr = 1'b1;
          end
        end
        K_EVENT: begin
          if (swStart) strb.load = 1'b1;
          else if (enQ && anyEdge) begin
            if (cntZero) begin
              strb.load = 1'b1; strb.irq = 1'b1; strb.toggle = 1'b1;
            end else strb.decr = 1'b1;
          end
        end
        K_ONESHOT: begin
          if (trig && (!runQ || retrig)) begin
            strb.load = 1'b1;
            runD      = 1'b1;
          end else if (runQ && countEn) begin
            if (cntZero) begin
              strb.irq = 1'b1; strb.toggle = 1'b1;
              runD     = 1'b0;
            end else strb.decr = 1'b1;
          end
        end
        K_PULSEW: begin
          if (enQ) begin
            if (!runQ) begin
              if (startEdge) begin
                strb.clear = 1'b1;
                runD       = 1'b1;
              end
            end else if (stopEdge) begin
              strb.capture = 1'b1; strb.irq = 1'b1;
              runD         = 1'b0;
            end else if (countEn) strb.incr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      runQ <= 1'b0;
    end else begin
      enQ  <= enD;
      runQ <= runD;
    end
  end
endmodule

// File: rtl/timer_chan_dp.sv
module timer_chan_dp
  import timer_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             dataWr,
  input  logic [CNT_W-1:0] dataWrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] capQ,
  output logic [CNT_W-1:0] dataQ,
  output logic             irqQ,
  output logic             togQ,
  output logic             cntZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN)       dataQ <= '0;
    else if (dataWr) dataQ <= dataWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cntQ <= '0;
    else if (strb.load)  cntQ <= dataQ;
    else if (strb.clear) cntQ <= '0;
    else if (strb.decr)  cntQ <= cntQ - ONE;
    else if (strb.incr)  cntQ <= cntQ + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ <= '0;
      irqQ <= 1'b0;
      togQ <= 1'b0;
    end else begin
      if (strb.capture) capQ <= cntQ;
      irqQ <= strb.irq;
      if (strb.toggle) togQ <= ~togQ;
    end
  end
endmodule

// File: rtl/timer_chan.sv
module timer_chan
  import timer_chan_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             timerIn,
  input  logic             swStart,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic [CNT_W-1:0] cntValue,
  output logic [CNT_W-1:0] capValue,
  output logic             irqPulse,
  output logic             toggleOut
);
  logic [MODE_W-1:0] modeQ;
  logic [CNT_W-1:0]  dataQ;
  strobe_t           strb;
  logic              cntZero;
  logic              modeWr, dataWr;

  assign modeWr = regWrEn & ~regAddr;
  assign dataWr = regWrEn & regAddr;

  timer_chan_ctrl #(.SYNC_N(SYNC_N)) ctrlInst (
    .clk(clk), .rstN(rstN), .timerIn(timerIn), .swStart(swStart),
    .countEn(countEn), .modeWr(modeWr), .modeWrData(regWrData[MODE_W-1:0]),
    .cntZero(cntZero), .modeQ(modeQ), .strb(strb)
  );

  timer_chan_dp #(.CNT_W(CNT_W)) dpInst (
    .clk(clk), .rstN(rstN), .strb(strb), .dataWr(dataWr),
    .dataWrData(regWrData), .cntQ(cntValue), .capQ(capValue),
    .dataQ(dataQ), .irqQ(irqPulse), .togQ(toggleOut), .cntZero(cntZero)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr) regRdData = dataQ;
    else         regRdData[MODE_W-1:0] = modeQ;
  end
endmodule

// File: rtl/timer_chan_chk.sv
module timer_chan_chk
  import timer_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              swStart,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [CNT_W-1:0]  regRdData,
  input logic [CNT_W-1:0]  cntValue,
  input logic [CNT_W-1:0]  capValue,
  input logic              irqPulse,
  input logic              toggleOut,
  input logic [MODE_W-1:0] modeWord,
  input logic [CNT_W-1:0]  dataWord
);
  kind_e kind;
  logic isUp, isDown, isHalt, modeWr;
  assign kind   = decodeKind(modeWord[3:1]);
  assign isUp   = (kind == K_CAPTURE) || (kind == K_PULSEW);
  assign isDown = (kind == K_INTERVAL) || (kind == K_EVENT) || (kind == K_ONESHOT);
  assign isHalt = (kind == K_HALT);
  assign modeWr = regWrEn && !regAddr;

  // R2
  rsvd_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> !regRdData[RSVD_BIT]);

  // R3
  down_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(isDown) |-> (cntValue <= $past(cntValue) || cntValue == $past(dataWord)));

  // R4
  up_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(isUp) |-> (cntValue >= $past(cntValue) || cntValue == '0));

  // R4
  capture_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capValue != $past(capValue)) |-> irqPulse);

  // R6
  toggle_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toggleOut != $past(toggleOut)) |-> irqPulse);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(isHalt) |-> (!irqPulse && $stable(cntValue) && $stable(capValue)));

  // R12
  mode_write_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeWr) && !swStart) |=> $stable(cntValue));
endmodule

bind timer_chan timer_chan_chk #(.CNT_W(CNT_W)) chkInst (
  .clk(clk), .rstN(rstN), .swStart(swStart), .regWrEn(regWrEn),
  .regAddr(regAddr), .regRdData(regRdData), .cntValue(cntValue),
  .capValue(capValue), .irqPulse(irqPulse), .toggleOut(toggleOut),
  .modeWord(modeQ), .dataWord(dataQ)
);

// File: tb/tb_timer_chan.sv
module tb_timer_chan;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countEn = 1'b0, timerIn = 1'b0, swStart = 1'b0;
  logic regWrEn = 1'b0, regAddr = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData, cntValue, capValue;
  logic irqPulse, toggleOut;

  int checks = 0, fails = 0;
  bit cmpOn = 1'b0, done = 1'b0;
  string phase = "R1";
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  timer_chan dut (
    .clk(clk), .rstN(rstN), .countEn(countEn), .timerIn(timerIn),
    .swStart(swStart), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cntValue(cntValue),
    .capValue(capValue), .irqPulse(irqPulse), .toggleOut(toggleOut)
  );

  // behavioural reference
  int mMode, mData, mCnt, mCap, mIrq, mTog, mEn, mRun;
  int s1, s2, s3;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mData = 0; mCnt = 0; mCap = 0; mIrq = 0; mTog = 0;
      mEn = 0; mRun = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int code, es, ts;
      bit rise, fall, anyE, stE, spE, tick, trig;
      rise = (s2 == 1) && (s3 == 0);
      fall = (s2 == 0) && (s3 == 1);
      code = (mMode >> 1) & 7;
      es = (mMode >> 6) & 3;
      ts = (mMode >> 8) & 7;
      anyE = (es == 0) ? fall : (es == 1) ? rise : (rise || fall);
      stE = (es % 2 == 1) ? rise : fall;
      spE = (es % 2 == 1) ? fall : rise;
      tick = countEn;
      mIrq = 0;
      if (regWrEn && !regAddr) begin
        mMode = regWrData & 16'hF7FF; mEn = 0; mRun = 0;
      end else begin
        bit valid;
        valid = (code == 0 || code == 2 || code == 3 || code == 4 || code == 6);
        if (code == 0) begin
          if (swStart) mCnt = mData;
          else if (mEn && tick) begin
            if (mCnt == 0) begin mCnt = mData; mIrq = 1; mTog ^= 1; end
            else mCnt--;
          end
        end else if (code == 2) begin
          if (swStart) mCnt = 0;
          else if (mEn) begin
            if (anyE) begin mCap = mCnt; mCnt = 0; mIrq = 1; end
            else if (tick) mCnt = (mCnt + 1) % 65536;
          end
        end else if (code == 3) begin
          if (swStart) mCnt = mData;
          else if (mEn && anyE) begin
            if (mCnt == 0) begin mCnt = mData; mIrq = 1; mTog ^= 1; end
            else mCnt--;
          end
        end else if (code == 4) begin
          trig = (ts == 0) ? swStart : (mEn && anyE);
          if (trig && (!mRun || (mMode & 1))) begin mCnt = mData; mRun = 1; end
          else if (mRun && tick) begin
            if (mCnt == 0) begin mIrq = 1; mTog ^= 1; mRun = 0; end
            else mCnt--;
          end
        end else if (code == 6) begin
          if (mEn) begin
            if (!mRun) begin
              if (stE) begin mCnt = 0; mRun = 1; end
            end else if (spE) begin mCap = mCnt; mIrq = 1; mRun = 0; end
            else if (tick) mCnt = (mCnt + 1) % 65536;
          end
        end
        if (swStart && valid) mEn = 1;
        if (regWrEn && regAddr) mData = regWrData;
      end
      s3 = s2; s2 = s1; s1 = timerIn;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && cmpOn && !done) begin
      chk(phase, "cnt", int'(cntValue), mCnt);
      chk(phase, "cap", int'(capValue), mCap);
      chk(phase, "irq", int'(irqPulse), mIrq);
      chk(phase, "tog", int'(toggleOut), mTog);
    end
  end

  task automatic wrReg(input bit addr, input logic [W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
  endtask

  // enMode: 0 off, 1 on, 2 pseudo-random
  task automatic run(input int n, input bit pinAct, input int enMode, input bit swAct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      countEn = (enMode == 1) ? 1'b1 : (enMode == 2) ? lfsr[0] : 1'b0;
      if (pinAct && lfsr[3:2] == 2'b00) timerIn = ~timerIn;
      swStart = swAct && (lfsr[9:5] == 5'd0);
    end
    @(negedge clk);
    swStart = 1'b0; countEn = 1'b0;
  endtask

  task automatic modeRun(input string req, input logic [15:0] m, input int n,
                         input bit pinAct, input int enMode, input bit swAct);
    phase = req;
    wrReg(1'b0, m);
    pulseStart();
    run(n, pinAct, enMode, swAct);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regAddr = 1'b0; #0;
    chk("R1", "mode", int'(regRdData), 0);
    chk("R1", "cnt", int'(cntValue), 0);
    chk("R1", "cap", int'(capValue), 0);
    chk("R1", "irq", int'(irqPulse), 0);
    chk("R1", "tog", int'(toggleOut), 0);
    regAddr = 1'b1; #1;
    chk("R1", "data", int'(regRdData), 0);
    regAddr = 1'b0;
    cmpOn = 1'b1;

    // R2 reserved bit and readback
    phase = "R2";
    wrReg(1'b0, 16'hFFFF);
    #1 chk("R2", "mode bit11 cleared", int'(regRdData), 16'hF7FF);
    wrReg(1'b0, 16'h0800);
    #1 chk("R2", "mode only bit11", int'(regRdData), 0);
    wrReg(1'b1, 16'h1234);
    regAddr = 1'b1; #1;
    chk("R2", "data", int'(regRdData), 16'h1234);
    regAddr = 1'b0;

    // R3 interval, R13 gated ticks
    wrReg(1'b1, 16'd5);
    modeRun("R3", 16'h0000, 80, 1'b0, 1, 1'b0);
    phase = "R13"; run(20, 1'b0, 0, 1'b0);
    run(120, 1'b0, 2, 1'b0);
    // R12 mode write stops the channel
    phase = "R12"; wrReg(1'b0, 16'h0000); run(30, 1'b1, 1, 1'b0);

    // R4 capture on rising edges, R5 other edge codes
    modeRun("R4", 16'h0044, 300, 1'b1, 2, 1'b1);
    modeRun("R5", 16'h0004, 200, 1'b1, 1, 1'b0);
    modeRun("R5", 16'h0084, 200, 1'b1, 2, 1'b0);
    modeRun("R5", 16'h00C4, 200, 1'b1, 2, 1'b0);

    // R6 event counter
    wrReg(1'b1, 16'd3);
    modeRun("R6", 16'h0046, 300, 1'b1, 2, 1'b1);
    modeRun("R6", 16'h0086, 200, 1'b1, 0, 1'b0);

    // R7 one-count, start-strobe and edge triggers
    wrReg(1'b1, 16'd6);
    modeRun("R7", 16'h0008, 40, 1'b0, 1, 1'b0);
    pulseStart(); run(40, 1'b0, 2, 1'b0);
    modeRun("R7", 16'h0148, 400, 1'b1, 2, 1'b0);
    // R8 retrigger
    modeRun("R8", 16'h0008, 5, 1'b0, 1, 1'b0);
    pulseStart(); run(20, 1'b0, 1, 1'b0);
    modeRun("R8", 16'h0009, 5, 1'b0, 1, 1'b0);
    pulseStart(); run(20, 1'b0, 1, 1'b0);
    modeRun("R8", 16'h0149, 400, 1'b1, 1, 1'b0);

    // R9 pulse width, both start polarities
    modeRun("R9", 16'h008C, 400, 1'b1, 2, 1'b1);
    modeRun("R9", 16'h00CC, 400, 1'b1, 1, 1'b0);

    // R10 prohibited codes
    modeRun("R10", 16'h0002, 150, 1'b1, 1, 1'b1);
    modeRun("R10", 16'h004E, 150, 1'b1, 1, 1'b1);

    // R11 synchroniser latency on an isolated rising edge
    phase = "R11";
    timerIn = 1'b0;
    wrReg(1'b0, 16'h0044);
    pulseStart();
    run(6, 1'b0, 0, 1'b0);
    begin
      int k;
      k = 0;
      timerIn = 1'b1;
      while (!irqPulse && k < 10) begin
        @(negedge clk);
        k++;
      end
      chk("R11", "edge to irq cycles", k, 3);
    end
    run(5, 1'b0, 0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule